// File: doc/BRIEF.md
# Paged Register Window Decoder

This block sits behind a 32-bit register-access slave port and turns each port offset into an offset in a register space wider than the port can reach directly. Offsets below 0xC00 go straight to the register with that offset. Offsets from 0xC00 up to 0xFFF form a movable window. Such an access reaches the register whose full 16-bit offset joins a 6-bit page number, held in a control register, with the low ten bits of the port offset.

Software reaches a far register in two steps. It first writes the page number, which is bits [15:10] of the target offset, into the control register. It then accesses 0xC00 plus bits [9:0] of the target. Before direct accesses it puts the page back to 0. Each request carries a byte count of 1, 2 or 4. A request with any other count, or one that is not aligned to its count, is refused with an error and changes nothing.

A small backing store stands in for the controller registers behind the decoder. One bank covers full offsets 0x000 to 0x03F and a second covers 0x1C00 to 0x1C3F.

Top module: `paged_reg_access`

## Requirements
- R1: After reset, rspValid is low, the control register reads 0 and every backing-store word reads 0.
- R2: A port offset below 0xC00 reaches the full offset equal to the port offset, whatever the page field holds.
- R3: A port offset from 0xC00 to 0xFFF reaches the full offset {page[5:0], offset[9:0]}. With page 0, the window therefore aliases the low direct offsets.
- R4: The control register sits at full offset 0x808. The page number is held in bits [18:13] and two direction-enable bits in bits [1:0]. All other bits read 0 and ignore writes. A write that touches only byte lanes 1 and 2 changes the page and leaves the enable bits as they were.
- R5: A 2-byte request with offset bit 0 set, or a 4-byte request with offset bits [1:0] not 00, is rejected. rspErr is raised, read data is 0 and no register changes.
- R6: reqSize holds the byte count. The values 1, 2 and 4 are legal. Any other value is rejected with rspErr, read data 0 and no change of state.
- R7: Each request, read or write, gets exactly one rspValid pulse in the cycle after it is taken. rspErr is high only together with rspValid.
- R8: Data travels on fixed byte lanes: lane k is bits [8k+7:8k], and the lanes used are chosen by offset bits [1:0]. A read returns 0 in the lanes outside the access. A write changes only the lanes inside it.
- R9: The backing store holds 16 words at full offsets 0x000–0x03F and 16 words at 0x1C00–0x1C3F. Every other full offset, apart from the control register, reads 0 and drops writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 12 | Port byte offset |
| reqSize | input | 3 | Byte count of the access |
| reqWdata | input | 32 | Write data on byte lanes |
| rspValid | output | 1 | Response strobe, one cycle after the request |
| rspErr | output | 1 | Request rejected (size or alignment) |
| rspRdata | output | 32 | Read data on byte lanes, 0 for writes and errors |

## Verification
Directed accesses first keep the direct region constant while the page is moved. This separates R2 from the window path. Window reads are then made with page 0, with page 7 and with page 2. Page 0 must alias the low bank, page 7 must reach the high bank and page 2 must reach the control register itself, so a wrong order of the page and offset fields shows up. Sub-word writes and reads at every lane offset check the lane placement. Odd-aligned and bad-size requests check that a rejected request leaves stored words untouched. A seeded random mix of sizes, regions and page changes, compared against a bench model, covers the order-dependent cases: a page write followed by a window access in the next cycle.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;

  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  // decoded request, handed from the control module to the datapath
  typedef struct packed {
    logic             go;
    logic             wrEn;
    logic             rdEn;
    logic             err;
    logic [LANES-1:0] byteEn;
    logic             hitCtrl;
    logic             hitLow;
    logic             hitHigh;
  } accessStrobes_t;

  function automatic logic [DATA_W-1:0] laneMask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int k = 0; k < LANES; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

endpackage

// File: rtl/pcsr_addr_compose.sv
module pcsr_addr_compose #(
  parameter int PORT_AW  = 12,
  parameter int LOW_BITS = 10,
  parameter int PAGE_W   = 6,
  parameter int FULL_AW  = 16,
  parameter int BOUNDARY = 'hC00
) (
  input  logic [PORT_AW-1:0]  accAddr,
  input  logic [PAGE_W-1:0]   pageSel,
  output logic [FULL_AW-1:0]  fullOff
);
  localparam logic [PORT_AW-1:0] BOUND_V = PORT_AW'(BOUNDARY);

  always_comb begin
    if (accAddr >= BOUND_V) fullOff = {pageSel, accAddr[LOW_BITS-1:0]};
    else                    fullOff = FULL_AW'(accAddr);
  end
endmodule

// File: rtl/pcsr_ctrl.sv
module pcsr_ctrl
  import pcsr_pkg::*;
#(
  parameter int PORT_AW    = 12,
  parameter int LOW_BITS   = 10,
  parameter int FULL_AW    = 16,
  parameter int IDX_W      = 4,
  parameter int BOUNDARY   = 'hC00,
  parameter int CTRL_OFF   = 'h808,
  parameter int LOW_WORDS  = 16,
  parameter int HIGH_WORDS = 16,
  parameter int HIGH_BASE  = 'h1C00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [PORT_AW-1:0] reqAddr,
  input  logic [2:0]         reqSize,
  input  logic [FULL_AW-1:0] fullOff,
  output accessStrobes_t     strb,
  output logic [IDX_W-1:0]   wordIdx
);
  localparam logic [PORT_AW-1:0] BOUND_V  = PORT_AW'(BOUNDARY);
  localparam logic [FULL_AW-1:0] CTRL_V   = FULL_AW'(CTRL_OFF);
  localparam logic [FULL_AW-1:0] LOW_END  = FULL_AW'(LOW_WORDS * 4);
  localparam logic [FULL_AW-1:0] HIGH_LO  = FULL_AW'(HIGH_BASE);
  localparam logic [FULL_AW-1:0] HIGH_END = FULL_AW'(HIGH_BASE + HIGH_WORDS * 4);

  logic               sizeOk;
  logic               misaligned;
  logic [LANES-1:0]   lanes;
  logic [FULL_AW-1:0] highRel;

  always_comb begin
    sizeOk     = 1'b0;
    misaligned = 1'b0;
    lanes      = '0;
    case (reqSize)
      3'd1: begin
        sizeOk = 1'b1;
        lanes  = 4'b0001 << reqAddr[1:0];
      end
      3'd2: begin
        sizeOk     = 1'b1;
        misaligned = reqAddr[0];
        lanes      = 4'b0011 << {reqAddr[1], 1'b0};
      end
      3'd4: begin
        sizeOk     = 1'b1;
        misaligned = |reqAddr[1:0];
        lanes      = 4'b1111;
      end
      default: ;
    endcase
  end

  assign highRel = fullOff - HIGH_LO;

  always_comb begin
    strb.go      = reqValid;
    strb.err     = reqValid & (~sizeOk | misaligned);
    strb.wrEn    = reqValid & reqWrite & ~strb.err;
    strb.rdEn    = reqValid & ~reqWrite & ~strb.err;
    strb.byteEn  = lanes;
    strb.hitCtrl = ({fullOff[FULL_AW-1:2], 2'b00} == CTRL_V);
    strb.hitLow  = (fullOff < LOW_END);
    strb.hitHigh = (fullOff >= HIGH_LO) && (fullOff < HIGH_END);
    wordIdx      = strb.hitHigh ? highRel[IDX_W+1:2] : fullOff[IDX_W+1:2];
  end

  // R2
  direct_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr < BOUND_V) |-> fullOff == FULL_AW'(reqAddr));

  // R3
  window_low_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqAddr >= BOUND_V) |-> fullOff[LOW_BITS-1:0] == reqAddr[LOW_BITS-1:0]);

  // R6
  bad_size_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !(reqSize inside {3'd1, 3'd2, 3'd4})) |-> strb.err);

  // R8
  lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.go && !strb.err) |-> $countones(strb.byteEn) == int'(reqSize));
endmodule

// File: rtl/pcsr_bank.sv
module pcsr_bank #(
  parameter int WORDS = 16,
  parameter int IDX_W = 4,
  parameter int DW    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] idx,
  input  logic [DW-1:0]    wrMask,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdWord
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
    end else if (wrEn) begin
      for (int i = 0; i < WORDS; i++)
        if (idx == IDX_W'(i)) mem[i] <= (mem[i] & ~wrMask) | (wrData & wrMask);
    end
  end

  always_comb begin
    rdWord = '0;
    for (int i = 0; i < WORDS; i++)
      if (idx == IDX_W'(i)) rdWord = mem[i];
  end
endmodule

// File: rtl/pcsr_data.sv
module pcsr_data
  import pcsr_pkg::*;
#(
  parameter int PAGE_W     = 6,
  parameter int PAGE_LSB   = 13,
  parameter int EN_W       = 2,
  parameter int IDX_W      = 4,
  parameter int LOW_WORDS  = 16,
  parameter int HIGH_WORDS = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  accessStrobes_t    strb,
  input  logic [IDX_W-1:0]  wordIdx,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [PAGE_W-1:0] pageSel,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata
);
  localparam logic [DATA_W-1:0] PAGE_BITS = DATA_W'(((1 << PAGE_W) - 1) << PAGE_LSB);
  localparam logic [DATA_W-1:0] EN_BITS   = DATA_W'((1 << EN_W) - 1);
  localparam logic [DATA_W-1:0] KEEP_MASK = PAGE_BITS | EN_BITS;

  logic [DATA_W-1:0] ctrlReg;
  logic [DATA_W-1:0] wrMask;
  logic [DATA_W-1:0] bankRd [2];
  logic [1:0]        bankHit;
  logic [DATA_W-1:0] selWord;

  assign wrMask  = laneMask(strb.byteEn);
  assign bankHit = {strb.hitHigh, strb.hitLow};
  assign pageSel = ctrlReg[PAGE_LSB +: PAGE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (strb.wrEn && strb.hitCtrl)
      ctrlReg <= ((ctrlReg & ~wrMask) | (reqWdata & wrMask)) & KEEP_MASK;
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam int WORDS = (b == 0) ? LOW_WORDS : HIGH_WORDS;
    pcsr_bank #(.WORDS(WORDS), .IDX_W(IDX_W), .DW(DATA_W)) i_bank (
      .clk    (clk),
      .rstN   (rstN),
      .wrEn   (strb.wrEn && bankHit[b]),
      .idx    (wordIdx),
      .wrMask (wrMask),
      .wrData (reqWdata),
      .rdWord (bankRd[b])
    );
  end

  always_comb begin
    if (strb.hitCtrl)      selWord = ctrlReg;
    else if (strb.hitLow)  selWord = bankRd[0];
    else if (strb.hitHigh) selWord = bankRd[1];
    else                   selWord = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
    end else begin
      rspValid <= strb.go;
      rspErr   <= strb.err;
      rspRdata <= strb.rdEn ? (selWord & wrMask) : '0;
    end
  end

  // R7
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.go |=> rspValid);

  // R7
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.go |=> !rspValid);

  // R5
  err_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && rspRdata == '0));

  // R5
  reject_keeps_ctrl_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.err |=> $stable(ctrlReg));

  // R4
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.hitCtrl && !strb.byteEn[0]) |=> $stable(ctrlReg[EN_W-1:0]));
endmodule

// File: rtl/paged_reg_access.sv
module paged_reg_access
  import pcsr_pkg::*;
#(
  parameter int PAGE_W     = 6,
  parameter int LOW_BITS   = 10,
  parameter int PAGE_LSB   = 13,
  parameter int EN_W       = 2,
  parameter int BOUNDARY   = 'hC00,
  parameter int CTRL_OFF   = 'h808,
  parameter int LOW_WORDS  = 16,
  parameter int HIGH_WORDS = 16,
  parameter int HIGH_BASE  = 'h1C00,
  localparam int PORT_AW   = LOW_BITS + 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [PORT_AW-1:0] reqAddr,
  input  logic [2:0]         reqSize,
  input  logic [DATA_W-1:0]  reqWdata,
  output logic               rspValid,
  output logic               rspErr,
  output logic [DATA_W-1:0]  rspRdata
);
  localparam int FULL_AW = PAGE_W + LOW_BITS;
  localparam int IDX_W   = $clog2((LOW_WORDS > HIGH_WORDS) ? LOW_WORDS : HIGH_WORDS);

  logic [PAGE_W-1:0]  pageSel;
  logic [FULL_AW-1:0] fullOff;
  logic [IDX_W-1:0]   wordIdx;
  accessStrobes_t     strb;

  pcsr_addr_compose #(
    .PORT_AW(PORT_AW), .LOW_BITS(LOW_BITS), .PAGE_W(PAGE_W),
    .FULL_AW(FULL_AW), .BOUNDARY(BOUNDARY)
  ) i_compose (
    .accAddr (reqAddr),
    .pageSel (pageSel),
    .fullOff (fullOff)
  );

  pcsr_ctrl #(
    .PORT_AW(PORT_AW), .LOW_BITS(LOW_BITS), .FULL_AW(FULL_AW), .IDX_W(IDX_W),
    .BOUNDARY(BOUNDARY), .CTRL_OFF(CTRL_OFF), .LOW_WORDS(LOW_WORDS),
    .HIGH_WORDS(HIGH_WORDS), .HIGH_BASE(HIGH_BASE)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .reqSize  (reqSize),
    .fullOff  (fullOff),
    .strb     (strb),
    .wordIdx  (wordIdx)
  );

  pcsr_data #(
    .PAGE_W(PAGE_W), .PAGE_LSB(PAGE_LSB), .EN_W(EN_W), .IDX_W(IDX_W),
    .LOW_WORDS(LOW_WORDS), .HIGH_WORDS(HIGH_WORDS)
  ) i_data (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wordIdx  (wordIdx),
    .reqWdata (reqWdata),
    .pageSel  (pageSel),
    .rspValid (rspValid),
    .rspErr   (rspErr),
    .rspRdata (rspRdata)
  );

  // R7
  err_only_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspValid);
endmodule

// File: tb/test_paged_reg_access.sv
module test_paged_reg_access;
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [31:0] KEEP = 32'h0007_E003;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [2:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic        rspErr;
  logic [31:0] rspRdata;

  always #4 clk = ~clk;

  paged_reg_access i_paged_reg_access (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [31:0] mCtrl;
  logic [31:0] mLow  [16];
  logic [31:0] mHigh [16];

  function automatic logic [3:0] lanesOf(input logic [11:0] a, input logic [2:0] s);
    case (s)
      3'd1: return 4'b0001 << a[1:0];
      3'd2: return 4'b0011 << {a[1], 1'b0};
      3'd4: return 4'b1111;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] expand(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  function automatic bit isBadSize(input logic [2:0] s);
    return !(s == 3'd1 || s == 3'd2 || s == 3'd4);
  endfunction

  function automatic bit isMis(input logic [11:0] a, input logic [2:0] s);
    return (s == 3'd2 && a[0]) || (s == 3'd4 && a[1:0] != 2'b00);
  endfunction

  function automatic logic [15:0] fullOf(input logic [11:0] a);
    if (a < 12'hC00) return {4'h0, a};
    return {mCtrl[18:13], a[9:0]};
  endfunction

  function automatic logic [31:0] modelRead(input logic [15:0] f);
    if (f[15:2] == 14'h0202) return mCtrl;
    if (f < 16'h0040) return mLow[f[5:2]];
    if (f >= 16'h1C00 && f < 16'h1C40) return mHigh[f[5:2]];
    return 32'h0;
  endfunction

  function automatic string tagOf(input logic [11:0] a, input logic [2:0] s);
    logic [15:0] f;
    if (isBadSize(s)) return "R6";
    if (isMis(a, s)) return "R5";
    f = fullOf(a);
    if (f[15:2] == 14'h0202) return "R4";
    if (a >= 12'hC00) return "R3";
    if (f < 16'h0040) return "R2";
    return "R9";
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic access(input bit wr, input logic [11:0] a, input logic [2:0] s,
                        input logic [31:0] d, input string tag,
                        output logic [31:0] got);
    bit          expErr;
    logic [15:0] f;
    logic [31:0] m;
    logic [31:0] expData;
    expErr  = isBadSize(s) || isMis(a, s);
    f       = fullOf(a);
    m       = expand(lanesOf(a, s));
    expData = (wr || expErr) ? 32'h0 : (modelRead(f) & m);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqSize = s; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    got = rspRdata;
    check("R7", "response strobe", {31'h0, rspValid}, 32'h1);
    check(tag, "error flag", {31'h0, rspErr}, {31'h0, expErr});
    check(tag, "read data", rspRdata, expData);
    if (wr && !expErr) begin
      if (f[15:2] == 14'h0202) mCtrl = ((mCtrl & ~m) | (d & m)) & KEEP;
      else if (f < 16'h0040) mLow[f[5:2]] = (mLow[f[5:2]] & ~m) | (d & m);
      else if (f >= 16'h1C00 && f < 16'h1C40) mHigh[f[5:2]] = (mHigh[f[5:2]] & ~m) | (d & m);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] s, input logic [31:0] d,
                    input string tag);
    logic [31:0] g;
    access(1'b1, a, s, d, tag, g);
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] s, input string tag,
                    output logic [31:0] g);
    access(1'b0, a, s, 32'h0, tag, g);
  endtask

  task automatic idleCheck();
    @(negedge clk);
    check("R7", "strobe idle", {31'h0, rspValid}, 32'h0);
  endtask

  initial begin
    logic [31:0] g;
    void'($urandom(32'd20240611));
    mCtrl = '0;
    for (int i = 0; i < 16; i++) begin mLow[i] = '0; mHigh[i] = '0; end

    repeat (3) @(negedge clk);
    check("R1", "strobe in reset", {31'h0, rspValid}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", "strobe after reset", {31'h0, rspValid}, 32'h0);
    rd(12'h808, 3'd4, "R1", g);
    check("R1", "control reset value", g, 32'h0);
    rd(12'h03C, 3'd4, "R1", g);
    rd(12'hC00, 3'd4, "R1", g);

    // R2: direct path ignores the page field
    wr(12'h004, 3'd4, 32'hA5A5_0001, "R2");
    wr(12'h808, 3'd4, 32'h0000_A003, "R4");
    rd(12'h004, 3'd4, "R2", g);
    check("R2", "direct with page 5", g, 32'hA5A5_0001);
    idleCheck();

    // R3: page 0 aliases low direct offsets
    wr(12'h808, 3'd4, 32'h0000_0003, "R4");
    rd(12'hC04, 3'd4, "R3", g);
    check("R3", "page 0 alias", g, 32'hA5A5_0001);
    // page 7 reaches the high bank
    wr(12'h808, 3'd4, 32'h0000_E003, "R4");
    wr(12'hC08, 3'd4, 32'h1234_5678, "R3");
    rd(12'hC08, 3'd4, "R3", g);
    check("R3", "page 7 window", g, 32'h1234_5678);
    rd(12'h008, 3'd4, "R3", g);
    check("R3", "high write did not hit low bank", g, 32'h0);
    // page 2 reaches the control register through the window
    wr(12'h808, 3'd4, 32'h0000_4003, "R4");
    rd(12'hC08, 3'd4, "R3", g);
    check("R3", "window onto control", g, 32'h0000_4003);

    // R4: byte write to lane 1 changes page bits, keeps enables
    wr(12'h809, 3'd1, 32'h0000_C000, "R4");
    rd(12'h808, 3'd4, "R4", g);
    check("R4", "enables kept by lane-1 write", g, 32'h0000_C003);
    wr(12'h808, 3'd4, 32'hFFFF_FFFF, "R4");
    rd(12'h808, 3'd4, "R4", g);
    check("R4", "only page and enable bits stick", g, 32'h0007_E003);
    wr(12'h80A, 3'd2, 32'h0000_0000, "R4");
    rd(12'h808, 3'd4, "R4", g);
    check("R4", "halfword clears upper page bits", g, 32'h0000_E003);
    wr(12'h808, 3'd4, 32'h0000_0003, "R4");

    // R5: misaligned requests
    wr(12'h00C, 3'd4, 32'h0BAD_F00D, "R5");
    wr(12'h00D, 3'd2, 32'hFFFF_FFFF, "R5");
    wr(12'h00E, 3'd4, 32'hFFFF_FFFF, "R5");
    rd(12'h00C, 3'd4, "R5", g);
    check("R5", "word kept after rejected writes", g, 32'h0BAD_F00D);
    rd(12'h00F, 3'd2, "R5", g);

    // R6: illegal sizes
    wr(12'h00C, 3'd3, 32'hFFFF_FFFF, "R6");
    wr(12'h808, 3'd0, 32'hFFFF_FFFF, "R6");
    rd(12'h00C, 3'd7, "R6", g);
    rd(12'h00C, 3'd4, "R6", g);
    check("R6", "word kept after bad sizes", g, 32'h0BAD_F00D);
    idleCheck();

    // R8: lane placement
    wr(12'h022, 3'd1, 32'h00AB_0000, "R8");
    wr(12'h021, 3'd1, 32'h0000_CD00, "R8");
    rd(12'h020, 3'd4, "R8", g);
    check("R8", "byte lanes merged", g, 32'h00AB_CD00);
    rd(12'h022, 3'd2, "R8", g);
    check("R8", "upper half only", g, 32'h00AB_0000);
    rd(12'h021, 3'd1, "R8", g);
    check("R8", "lane 1 only", g, 32'h0000_CD00);

    // R9: unmapped offsets
    wr(12'h400, 3'd4, 32'hDEAD_BEEF, "R9");
    rd(12'h400, 3'd4, "R9", g);
    check("R9", "unmapped reads zero", g, 32'h0);
    wr(12'h808, 3'd4, 32'h0000_E003, "R4");
    rd(12'hC40, 3'd4, "R9", g);
    check("R9", "past high bank reads zero", g, 32'h0);

    // seeded random mix
    for (int i = 0; i < 900; i++) begin
      logic [11:0] a;
      logic [2:0]  s;
      logic [31:0] d;
      int          region;
      bit          w;
      region = int'($urandom % 6);
      d = $urandom;
      w = ($urandom % 2) == 1;
      if (($urandom % 10) < 8) begin
        case ($urandom % 3)
          0: s = 3'd1;
          1: s = 3'd2;
          default: s = 3'd4;
        endcase
      end else s = 3'($urandom % 8);
      case (region)
        0: a = 12'($urandom % 64);
        1: a = 12'h808 + 12'($urandom % 4);
        2: a = 12'hC00 + 12'($urandom % 64);
        3: a = 12'hC00 + 12'($urandom % 1024);
        4: a = 12'h040 + 12'($urandom % 12'hBC0);
        default: a = 12'h808;
      endcase
      if (region == 5) begin
        logic [5:0] p;
        case ($urandom % 5)
          0: p = 6'd0;
          1: p = 6'd7;
          2: p = 6'd2;
          3: p = 6'd3;
          default: p = 6'($urandom);
        endcase
        wr(12'h808, 3'd4, {13'h0, p, 11'h0, 2'($urandom)}, "R4");
      end else begin
        access(w, a, s, d, tagOf(a, s), d);
      end
      if (($urandom % 16) == 0) idleCheck();
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule